// File: doc/BRIEF.md
# Flash Block Erase-and-Verify Sequencer

This block runs the erase of one block of an on-chip flash array and then proves the result. After a start strobe with a valid block choice it raises the array's control strobes in a fixed order: write enable, block choice, watchdog enable, erase setup and the erase pulse. It then lowers them in reverse order and enters erase-verify mode. Each step is held for a programmable count of clock cycles before the next one begins. The erase pulse has its own wider counter, because it lasts far longer than the other waits.

In verify mode the block's words are visited from its first address upward. Each address gets a dummy write of 0xFF, a settle wait and a 16-bit read, and only an all-ones word passes. A failing word ends the round. The sequencer leaves verify mode and, while attempts remain, erases the same block again without dropping write enable. When every word passes it reports done; when the attempt budget is used up it reports fail. Blocks are erased one at a time, and pre-programming the block to zeros is not part of the flow.

States and transitions: ST_IDLE goes to ST_SWE_ON on an accepted start, or to ST_REJECT for one cycle on a bad block choice. The erase path runs ST_SWE_ON → ST_BLK_LOAD → ST_WDT_ON → ST_ESU_ON → ST_ERS_ON → ST_ERS_OFF → ST_ESU_OFF → ST_WDT_OFF → ST_EV_ON. The verify loop runs ST_DUMMY_WR → ST_SETTLE → ST_READ; a passing word that is not the last returns to ST_DUMMY_WR, and the last word or any failing word goes to ST_EV_OFF. From ST_EV_OFF the sequencer goes to ST_DONE, to ST_FAIL, or back to ST_BLK_LOAD for a retry. ST_DONE, ST_FAIL and ST_REJECT each return to ST_IDLE after one cycle.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset and while idle, every output is low.
- R2: A start taken in idle with a one-hot `blk_sel` raises `fl_swe` on the next cycle for `dly_swe`+1 cycles. Then `fl_blk` shows the selection for one cycle before `wdt_en` rises, and `wdt_en` is high for one cycle before `fl_esu` rises.
- R3: `fl_esu` stays high alone for `dly_esu`+1 cycles, then `fl_ers` is high for `dly_ers`+1 cycles. After that `fl_ers` is low with `fl_esu` still high for `dly_ers_off`+1 cycles, and `fl_esu` is low with `wdt_en` still high for `dly_esu_off`+1 cycles. Then one cycle follows with only `fl_swe` and `fl_blk` high.
- R4: `fl_ev` is held for `dly_ev`+1 cycles before the first dummy write. That write is at the block's first address, BLK_BASE + k·BLK_WORDS, where bit k of `blk_sel` is set.
- R5: Each address gets a one-cycle `arr_wr` with `arr_wdata` = 0xFF, then `dly_settle`+1 cycles, then a one-cycle `arr_rd`. The word passes only if `arr_rdata` is 0xFFFF, and a pass moves to the next address.
- R6: When the last word of the block passes, `fl_ev` drops and `fl_swe` alone (with `fl_blk`) is held `dly_ev_off`+1 cycles. Then every strobe is low and `done` pulses for one cycle.
- R7: When a word fails, `fl_ev` drops for `dly_ev_off`+1 cycles. If fewer than MAX_TRY erase rounds have run, the sequence restarts at the block-load step with `fl_swe` still high. A round whose words all pass still ends in `done`, including the round numbered MAX_TRY.
- R8: When the round numbered MAX_TRY fails, every strobe drops and `fail` pulses for one cycle.
- R9: A start whose `blk_sel` is not one-hot (zero or several bits) gives a one-cycle `sel_err` pulse and leaves every strobe and `fl_blk` low.
- R10: A start raised while the sequencer is busy has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to erase the selected block |
| blk_sel | input | NBLK | One-hot block choice |
| dly_swe | input | DW | Wait after write enable rises |
| dly_esu | input | DW | Wait after erase setup rises |
| dly_ers | input | ZW | Length of the erase pulse |
| dly_ers_off | input | DW | Wait after the erase pulse drops |
| dly_esu_off | input | DW | Wait after erase setup drops |
| dly_ev | input | DW | Wait after erase-verify rises |
| dly_settle | input | DW | Wait between dummy write and read |
| dly_ev_off | input | DW | Wait after erase-verify drops |
| arr_rdata | input | 16 | Word read from the array |
| fl_swe | output | 1 | Write-enable strobe to the array |
| fl_esu | output | 1 | Erase-setup strobe |
| fl_ers | output | 1 | Erase strobe |
| fl_ev | output | 1 | Erase-verify strobe |
| fl_blk | output | NBLK | Block choice driven to the array |
| wdt_en | output | 1 | Watchdog enable around the erase pulse |
| arr_addr | output | AW | Word address for verify accesses |
| arr_wr | output | 1 | Dummy-write strobe |
| arr_wdata | output | 8 | Dummy-write data |
| arr_rd | output | 1 | Verify read strobe |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |
| sel_err | output | 1 | One-cycle pulse for a rejected block choice |

## Verification
All outputs are decoded from the state register, so a start driven before a rising edge shows up at the ports just after that edge. Each step then lasts exactly its programmed count plus one cycle. For every run the bench computes the full list of expected port steps and queues each with its cycle count and, for verify accesses, its address. A monitor samples 2 ns after each rising edge, checks the front entry every cycle and pops it once its count is used up. A missing, extra or late cycle therefore shifts the whole queue out of step and is reported.

// File: rtl/fe_pkg.sv
package fe_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_REJECT,
        ST_SWE_ON,
        ST_BLK_LOAD,
        ST_WDT_ON,
        ST_ESU_ON,
        ST_ERS_ON,
        ST_ERS_OFF,
        ST_ESU_OFF,
        ST_WDT_OFF,
        ST_EV_ON,
        ST_DUMMY_WR,
        ST_SETTLE,
        ST_READ,
        ST_EV_OFF,
        ST_DONE,
        ST_FAIL
    } fe_state_e;

    typedef struct packed {
        logic swe;
        logic esu;
        logic ers;
        logic ev;
        logic wdt;
        logic wr;
        logic rd;
        logic done;
        logic fail;
        logic err;
        logic blk_on;
    } fe_ctl_t;

    localparam logic [15:0] ERASED_WORD = 16'hFFFF;
    localparam logic [7:0]  DUMMY_BYTE  = 8'hFF;

endpackage

// File: rtl/fe_down_timer.sv
module fe_down_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // a finished count stays at zero until the next load
    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> cnt == '0);

endmodule

// File: rtl/fe_addr_walker.sv
module fe_addr_walker #(
    parameter int NBLK      = 4,
    parameter int BLK_WORDS = 8,
    parameter int BLK_BASE  = 256,
    parameter int AW        = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NBLK-1:0] blk_sel,
    input  logic            restart,
    input  logic            step,
    output logic [AW-1:0]   addr,
    output logic            last
);

    localparam int OW = (BLK_WORDS > 1) ? $clog2(BLK_WORDS) : 1;
    localparam logic [OW-1:0] LAST_OFF = OW'(BLK_WORDS - 1);

    logic [OW-1:0] off;
    logic [AW-1:0] base;

    always_comb begin
        base = AW'(BLK_BASE);
        for (int k = 0; k < NBLK; k++) begin
            if (blk_sel[k]) begin
                base = AW'(BLK_BASE) + AW'(k * BLK_WORDS);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off <= '0;
        end else if (restart) begin
            off <= '0;
        end else if (step && off != LAST_OFF) begin
            off <= off + 1'b1;
        end
    end

    assign addr = base + AW'(off);
    assign last = (off == LAST_OFF);

    p_off_in_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        off <= LAST_OFF);

    p_restart_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (off == '0));

endmodule

// File: rtl/fe_retry_count.sv
module fe_retry_count #(
    parameter int MAX_TRY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic spent
);

    localparam int NW = $clog2(MAX_TRY + 1) + 1;
    localparam logic [NW-1:0] LIMIT = NW'(MAX_TRY);

    logic [NW-1:0] n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n <= NW'(1);
        end else if (clear) begin
            n <= NW'(1);
        end else if (bump && n != LIMIT) begin
            n <= n + 1'b1;
        end
    end

    assign spent = (n == LIMIT);

    p_try_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (n >= NW'(1)) && (n <= LIMIT));

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fe_pkg::*;
#(
    parameter int NBLK      = 4,
    parameter int BLK_WORDS = 8,
    parameter int BLK_BASE  = 256,
    parameter int AW        = 12,
    parameter int DW        = 8,
    parameter int ZW        = 16,
    parameter int MAX_TRY   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NBLK-1:0] blk_sel,
    input  logic [DW-1:0]   dly_swe,
    input  logic [DW-1:0]   dly_esu,
    input  logic [ZW-1:0]   dly_ers,
    input  logic [DW-1:0]   dly_ers_off,
    input  logic [DW-1:0]   dly_esu_off,
    input  logic [DW-1:0]   dly_ev,
    input  logic [DW-1:0]   dly_settle,
    input  logic [DW-1:0]   dly_ev_off,
    input  logic [15:0]     arr_rdata,
    output logic            fl_swe,
    output logic            fl_esu,
    output logic            fl_ers,
    output logic            fl_ev,
    output logic [NBLK-1:0] fl_blk,
    output logic            wdt_en,
    output logic [AW-1:0]   arr_addr,
    output logic            arr_wr,
    output logic [7:0]      arr_wdata,
    output logic            arr_rd,
    output logic            busy,
    output logic            done,
    output logic            fail,
    output logic            sel_err
);

    fe_state_e       state, nxt;
    fe_ctl_t         ctl;
    logic [NBLK-1:0] blk_q;
    logic            ok_q;
    logic            sel_ok, accept;
    logic            short_load, long_load;
    logic [DW-1:0]   short_val;
    logic            short_exp, long_exp;
    logic            last_word, word_pass, spent;

    assign sel_ok    = (blk_sel != '0) && ((blk_sel & (blk_sel - 1'b1)) == '0);
    assign accept    = (state == ST_IDLE) && start && sel_ok;
    assign word_pass = (arr_rdata == ERASED_WORD);

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // ---- next state ----
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start) nxt = sel_ok ? ST_SWE_ON : ST_REJECT;
            ST_REJECT:   nxt = ST_IDLE;
            ST_SWE_ON:   if (short_exp) nxt = ST_BLK_LOAD;
            ST_BLK_LOAD: nxt = ST_WDT_ON;
            ST_WDT_ON:   nxt = ST_ESU_ON;
            ST_ESU_ON:   if (short_exp) nxt = ST_ERS_ON;
            ST_ERS_ON:   if (long_exp) nxt = ST_ERS_OFF;
            ST_ERS_OFF:  if (short_exp) nxt = ST_ESU_OFF;
            ST_ESU_OFF:  if (short_exp) nxt = ST_WDT_OFF;
            ST_WDT_OFF:  nxt = ST_EV_ON;
            ST_EV_ON:    if (short_exp) nxt = ST_DUMMY_WR;
            ST_DUMMY_WR: nxt = ST_SETTLE;
            ST_SETTLE:   if (short_exp) nxt = ST_READ;
            ST_READ:     nxt = (word_pass && !last_word) ? ST_DUMMY_WR : ST_EV_OFF;
            ST_EV_OFF: begin
                if (short_exp) begin
                    if (ok_q)       nxt = ST_DONE;
                    else if (spent) nxt = ST_FAIL;
                    else            nxt = ST_BLK_LOAD;
                end
            end
            ST_DONE:     nxt = ST_IDLE;
            ST_FAIL:     nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // ---- timer loads on entry to a wait state ----
    always_comb begin
        short_load = 1'b0;
        short_val  = '0;
        if (nxt != state) begin
            unique case (nxt)
                ST_SWE_ON:  begin short_load = 1'b1; short_val = dly_swe;     end
                ST_ESU_ON:  begin short_load = 1'b1; short_val = dly_esu;     end
                ST_ERS_OFF: begin short_load = 1'b1; short_val = dly_ers_off; end
                ST_ESU_OFF: begin short_load = 1'b1; short_val = dly_esu_off; end
                ST_EV_ON:   begin short_load = 1'b1; short_val = dly_ev;      end
                ST_SETTLE:  begin short_load = 1'b1; short_val = dly_settle;  end
                ST_EV_OFF:  begin short_load = 1'b1; short_val = dly_ev_off;  end
                default:    begin short_load = 1'b0; short_val = '0;          end
            endcase
        end
    end

    assign long_load = (nxt == ST_ERS_ON) && (state != ST_ERS_ON);

    fe_down_timer #(.W(DW)) u_short_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (short_load),
        .load_val (short_val),
        .expired  (short_exp)
    );

    fe_down_timer #(.W(ZW)) u_long_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (long_load),
        .load_val (dly_ers),
        .expired  (long_exp)
    );

    // ---- block latch and round result ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q <= '0;
            ok_q  <= 1'b0;
        end else begin
            if (accept) blk_q <= blk_sel;
            if (state == ST_READ) ok_q <= word_pass;
        end
    end

    fe_addr_walker #(
        .NBLK      (NBLK),
        .BLK_WORDS (BLK_WORDS),
        .BLK_BASE  (BLK_BASE),
        .AW        (AW)
    ) u_walker (
        .clk     (clk),
        .rst_n   (rst_n),
        .blk_sel (blk_q),
        .restart (state == ST_EV_ON),
        .step    ((state == ST_READ) && word_pass && !last_word),
        .addr    (arr_addr),
        .last    (last_word)
    );

    fe_retry_count #(.MAX_TRY(MAX_TRY)) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .bump  ((state == ST_EV_OFF) && short_exp && !ok_q && !spent),
        .spent (spent)
    );

    // ---- outputs decoded from state ----
    always_comb begin
        ctl = '0;
        unique case (state)
            ST_IDLE:     ctl = '0;
            ST_REJECT:   ctl.err = 1'b1;
            ST_SWE_ON:   ctl.swe = 1'b1;
            ST_BLK_LOAD: begin ctl.swe = 1'b1; ctl.blk_on = 1'b1; end
            ST_WDT_ON:   begin ctl.swe = 1'b1; ctl.blk_on = 1'b1; ctl.wdt = 1'b1; end
            ST_ESU_ON, ST_ERS_OFF: begin
                ctl.swe = 1'b1; ctl.blk_on = 1'b1; ctl.wdt = 1'b1; ctl.esu = 1'b1;
            end
            ST_ERS_ON: begin
                ctl.swe = 1'b1; ctl.blk_on = 1'b1; ctl.wdt = 1'b1;
                ctl.esu = 1'b1; ctl.ers = 1'b1;
            end
            ST_ESU_OFF:  begin ctl.swe = 1'b1; ctl.blk_on = 1'b1; ctl.wdt = 1'b1; end
            ST_WDT_OFF, ST_EV_OFF: begin ctl.swe = 1'b1; ctl.blk_on = 1'b1; end
            ST_EV_ON, ST_SETTLE: begin ctl.swe = 1'b1; ctl.blk_on = 1'b1; ctl.ev = 1'b1; end
            ST_DUMMY_WR: begin
                ctl.swe = 1'b1; ctl.blk_on = 1'b1; ctl.ev = 1'b1; ctl.wr = 1'b1;
            end
            ST_READ: begin
                ctl.swe = 1'b1; ctl.blk_on = 1'b1; ctl.ev = 1'b1; ctl.rd = 1'b1;
            end
            ST_DONE:     ctl.done = 1'b1;
            ST_FAIL:     ctl.fail = 1'b1;
            default:     ctl = '0;
        endcase
    end

    assign fl_swe    = ctl.swe;
    assign fl_esu    = ctl.esu;
    assign fl_ers    = ctl.ers;
    assign fl_ev     = ctl.ev;
    assign wdt_en    = ctl.wdt;
    assign arr_wr    = ctl.wr;
    assign arr_rd    = ctl.rd;
    assign arr_wdata = ctl.wr ? DUMMY_BYTE : 8'h00;
    assign fl_blk    = ctl.blk_on ? blk_q : '0;
    assign done      = ctl.done;
    assign fail      = ctl.fail;
    assign sel_err   = ctl.err;
    assign busy      = (state != ST_IDLE);

    // ---- assertions ----
    p_ers_inside_esu_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fl_ers |-> (fl_esu && wdt_en && fl_swe));

    p_ev_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fl_ev |-> (!fl_esu && !fl_ers && !wdt_en));

    p_dummy_under_ev_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr |-> (fl_ev && arr_wdata == 8'hFF && !arr_rd));

    p_bad_word_exits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd && arr_rdata != 16'hFFFF) |=> (state == ST_EV_OFF));

    p_done_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_fail_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> (!fail && !done));

    p_reject_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_err |-> (!fl_swe && fl_blk == '0));

    p_blk_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fl_blk));

    p_swe_only_from_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_swe) |-> ($past(state) == ST_IDLE));

endmodule

// File: tb/flash_erase_seq_test.sv
`timescale 1ns/1ps
module flash_erase_seq_test;

    localparam int NBLK = 4, BLK_WORDS = 8, BLK_BASE = 256, AW = 12;
    localparam int DW = 8, ZW = 16, MAX_TRY = 3;
    localparam int DX = 2, DY = 1, DZ = 5, DA = 1, DB = 2, DG = 1, DE = 1, DH = 2;

    // expected vector bits: {swe,esu,ers,ev,wdt,wr,rd,done,fail,err}
    localparam logic [9:0] V_SWE  = 10'b1000000000;
    localparam logic [9:0] V_ESU  = 10'b0100000000;
    localparam logic [9:0] V_ERS  = 10'b0010000000;
    localparam logic [9:0] V_EV   = 10'b0001000000;
    localparam logic [9:0] V_WDT  = 10'b0000100000;
    localparam logic [9:0] V_WR   = 10'b0000010000;
    localparam logic [9:0] V_RD   = 10'b0000001000;
    localparam logic [9:0] V_DONE = 10'b0000000100;
    localparam logic [9:0] V_FAIL = 10'b0000000010;
    localparam logic [9:0] V_ERR  = 10'b0000000001;

    typedef struct {
        logic [9:0]      v;
        logic [NBLK-1:0] blk;
        int              n;
        logic [AW-1:0]   addr;
        bit              ca;
        string           tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n;
    logic start;
    logic [NBLK-1:0] blk_sel;
    logic [15:0] arr_rdata;
    logic fl_swe, fl_esu, fl_ers, fl_ev, wdt_en, arr_wr, arr_rd;
    logic busy, done, fail, sel_err;
    logic [NBLK-1:0] fl_blk;
    logic [AW-1:0] arr_addr;
    logic [7:0] arr_wdata;

    int total = 0;
    int bad = 0;
    exp_t q[$];
    bit item_bad = 0;

    // array model
    bit            bad_en = 0;
    logic [AW-1:0] bad_addr = '0;
    int            bad_rounds = 0;
    logic [15:0]   bad_val = 16'h0000;
    int            ers_cnt = 0;

    always #10 clk = ~clk;

    always @(negedge fl_ers) ers_cnt++;

    assign arr_rdata = (bad_en && arr_addr == bad_addr && ers_cnt <= bad_rounds)
                       ? bad_val : 16'hFFFF;

    flash_erase_seq #(
        .NBLK(NBLK), .BLK_WORDS(BLK_WORDS), .BLK_BASE(BLK_BASE), .AW(AW),
        .DW(DW), .ZW(ZW), .MAX_TRY(MAX_TRY)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_sel(blk_sel),
        .dly_swe(DW'(DX)), .dly_esu(DW'(DY)), .dly_ers(ZW'(DZ)),
        .dly_ers_off(DW'(DA)), .dly_esu_off(DW'(DB)), .dly_ev(DW'(DG)),
        .dly_settle(DW'(DE)), .dly_ev_off(DW'(DH)), .arr_rdata(arr_rdata),
        .fl_swe(fl_swe), .fl_esu(fl_esu), .fl_ers(fl_ers), .fl_ev(fl_ev),
        .fl_blk(fl_blk), .wdt_en(wdt_en), .arr_addr(arr_addr), .arr_wr(arr_wr),
        .arr_wdata(arr_wdata), .arr_rd(arr_rd), .busy(busy), .done(done),
        .fail(fail), .sel_err(sel_err)
    );

    // ---- monitor: compare each cycle against the queue front ----
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            logic [9:0] obs;
            obs = {fl_swe, fl_esu, fl_ers, fl_ev, wdt_en, arr_wr, arr_rd, done, fail, sel_err};
            if (!item_bad) begin
                if (obs !== q[0].v || fl_blk !== q[0].blk) begin
                    $display("FAIL %s: strobes=%b blk=%b expected strobes=%b blk=%b",
                             q[0].tag, obs, fl_blk, q[0].v, q[0].blk);
                    item_bad = 1;
                end else if (q[0].ca && arr_addr !== q[0].addr) begin
                    $display("FAIL %s: addr=%0d expected %0d", q[0].tag, arr_addr, q[0].addr);
                    item_bad = 1;
                end else if (q[0].v[4] && arr_wdata !== 8'hFF) begin
                    $display("FAIL %s: wdata=%h expected ff", q[0].tag, arr_wdata);
                    item_bad = 1;
                end
            end
            q[0].n = q[0].n - 1;
            if (q[0].n == 0) begin
                total++;
                if (item_bad) bad++;
                item_bad = 0;
                void'(q.pop_front());
            end
        end
    end

    task automatic push(input logic [9:0] v, input logic [NBLK-1:0] b, input int n,
                        input logic [AW-1:0] a, input bit ca, input string tag);
        exp_t e;
        e.v = v; e.blk = b; e.n = n; e.addr = a; e.ca = ca; e.tag = tag;
        q.push_back(e);
    endtask

    // one erase round from the block-load step through the verify reads
    task automatic push_round(input logic [NBLK-1:0] s, input int base, input int fail_off);
        push(V_SWE, s, 1, '0, 0, "R2 block load");
        push(V_SWE | V_WDT, s, 1, '0, 0, "R2 watchdog on");
        push(V_SWE | V_WDT | V_ESU, s, DY + 1, '0, 0, "R3 erase setup");
        push(V_SWE | V_WDT | V_ESU | V_ERS, s, DZ + 1, '0, 0, "R3 erase pulse");
        push(V_SWE | V_WDT | V_ESU, s, DA + 1, '0, 0, "R3 erase off");
        push(V_SWE | V_WDT, s, DB + 1, '0, 0, "R3 setup off");
        push(V_SWE, s, 1, '0, 0, "R3 watchdog off");
        push(V_SWE | V_EV, s, DG + 1, '0, 0, "R4 verify on");
        for (int i = 0; i < BLK_WORDS; i++) begin
            push(V_SWE | V_EV | V_WR, s, 1, AW'(base + i), 1,
                 (i == 0) ? "R4 first dummy write" : "R5 dummy write");
            push(V_SWE | V_EV, s, DE + 1, '0, 0, "R5 settle");
            push(V_SWE | V_EV | V_RD, s, 1, AW'(base + i), 1, "R5 verify read");
            if (i == fail_off) break;
        end
    endtask

    task automatic run_erase(input logic [NBLK-1:0] s, input int boff, input int brounds,
                             input logic [15:0] bval, input bit poke);
        int k = 0;
        int base;
        for (int j = 0; j < NBLK; j++) if (s[j]) k = j;
        base = BLK_BASE + k * BLK_WORDS;
        @(negedge clk);
        bad_en = (boff >= 0);
        bad_addr = AW'(base + boff);
        bad_rounds = brounds;
        bad_val = bval;
        ers_cnt = 0;
        blk_sel = s;
        start = 1'b1;
        push(V_SWE, '0, DX + 1, '0, 0, "R2 write enable");
        for (int r = 1; r <= MAX_TRY; r++) begin
            bit fails;
            fails = (boff >= 0) && (r <= brounds);
            push_round(s, base, fails ? boff : -1);
            if (!fails) begin
                push(V_SWE, s, DH + 1, '0, 0, "R6 verify off");
                push(V_DONE, '0, 1, '0, 0, "R6 done pulse");
                break;
            end
            push(V_SWE, s, DH + 1, '0, 0, "R7 verify off after bad word");
            if (r == MAX_TRY) begin
                push(V_FAIL, '0, 1, '0, 0, "R8 fail pulse");
                break;
            end
        end
        push('0, '0, 3, '0, 0, "R1 back to idle");
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (6) @(negedge clk);
            blk_sel = 4'b0011; start = 1'b1;   // R10: busy, bad select
            @(negedge clk);
            start = 1'b0;
            repeat (12) @(negedge clk);
            blk_sel = 4'b1000; start = 1'b1;   // R10: busy, valid select
            @(negedge clk);
            start = 1'b0;
        end
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    task automatic run_reject(input logic [NBLK-1:0] s);
        @(negedge clk);
        blk_sel = s;
        start = 1'b1;
        push(V_ERR, '0, 1, '0, 0, "R9 select error pulse");
        push('0, '0, 3, '0, 0, "R9 no strobe after reject");
        @(negedge clk);
        start = 1'b0;
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        blk_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        total++;
        if ({fl_swe, fl_esu, fl_ers, fl_ev, wdt_en, arr_wr, arr_rd, busy, done, fail, sel_err} !== '0
            || fl_blk !== '0) begin
            bad++;
            $display("FAIL R1: outputs not idle after reset, expected all zero");
        end

        run_erase(4'b0001, -1, 0, 16'h0000, 0);    // clean block 0
        run_erase(4'b0100, 3, 1, 16'h00F0, 0);     // one retry, then pass
        run_erase(4'b0010, 7, 99, 16'hFFFE, 0);    // last word never clears: fail
        run_erase(4'b1000, 0, 2, 16'h7FFF, 0);     // passes on the final allowed round
        run_reject(4'b0101);
        run_reject(4'b0000);
        run_erase(4'b0001, -1, 0, 16'h0000, 1);    // starts while busy are ignored

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule